// File: doc/BRIEF.md
# Grouped Interrupt Aggregator with Batched Delivery

This block gathers source interrupt lines into groups of 32 and drives one output interrupt for each group. For each group, firmware sees two words through a 32-bit register port: an enable word and a status word. A group delivers its enabled, active sources as a single batch. It loads the batch into the status word and raises the group output. Firmware then services the sources and acknowledges each one by writing ones to the status word.

Delivery is atomic per batch. While a batch is still open (the status word is nonzero) or the group is masked, newly selected sources go into a hidden pending word. They reach status only after firmware has acknowledged every bit of the open batch. Enable writes are sticky: a write can only add enable bits. A write that leaves the enable word unchanged is instead read as a mask or unmask request against the last value written. Addresses in the register window that hold no group register act as plain storage.

Top module: `intagg_top`

## Requirements
- R1: After reset, every readable word reads zero and every group output is low.
- R2: Group n has its enable register at byte offset n*0x100 and its status register at n*0x100+4. The group is taken from address bits [11:8]. Reading the enable register returns the last word written to it. Reading the status register returns the current status.
- R3: A write to any other address below 0x808 is stored, and a read of that address returns the stored word. A write at 0x808 or above is dropped, and a read there returns zero.
- R4: On any cycle where (source lines AND enable word) is nonzero, and the group's mask word and status are both zero, status is loaded with that selected set and the output is high from the next cycle.
- R5: Source lines whose enable bit is zero have no effect on status, pending or the output.
- R6: If a selected set arrives while status is nonzero, it is ORed into pending. Status and the output stay unchanged.
- R7: An enable write ORs its data into the enable word, so software never clears an enable bit. A write of zero while the enable word is zero only updates the readable value.
- R8: An enable write that leaves the enable word unchanged, and has no bit set that was clear in the last written value, sets the changed bits in the mask word. While the mask word is nonzero, selected sets go to pending instead of status.
- R9: An enable write that leaves the enable word unchanged and sets a bit that was clear in the last written value removes the changed bits from the mask word.
- R10: A status write clears the status bits written as one. A status write of zero has no effect.
- R11: A status write of 0xFFFFFFFF clears status and does nothing else. The output level and the pending word are kept.
- R12: When any other nonzero status write leaves status at zero, a nonzero pending word moves into status, pending clears, and the output stays high. If pending is zero, the output goes low on the next cycle.
- R13: When a register write and a source event reach the same group in one cycle, the write takes effect first, and the event is judged against the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 12 | Byte address for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_lines | input | 288 | Source lines; group g uses bits [g*32+31:g*32] |
| irq_out | output | 9 | One interrupt output per group |

## Verification
The hardest state to reach is a pending word that is loaded while the group is masked or while a batch is open, because the pending word cannot be read. The stimulus reaches it in several ways. One-cycle source pulses arrive during an open batch. A masking enable write is followed by a pulse and then an unmask. An all-ones status write clears status but keeps the pending word. In each case the hidden word shows up later in the status register, after a nonzero acknowledge empties status. A same-cycle enable write and source pulse show that the write takes effect first.

// File: rtl/intagg_pkg.sv
package intagg_pkg;

    parameter int unsigned WORD_W    = 32;
    parameter int unsigned ADDR_W    = 12;
    parameter int unsigned GRP_LO    = 8;
    parameter int unsigned GRP_W     = 4;
    parameter int unsigned WIN_BYTES = 32'h808;
    parameter int unsigned WIN_WORDS = WIN_BYTES / 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_ENABLE,
        ACC_STATUS,
        ACC_PLAIN
    } acc_kind_e;

    typedef struct packed {
        word_t enable;
        word_t mask;
        word_t pending;
        word_t en_reg;
        word_t status;
        logic  irq;
    } grp_state_t;

    // Enable-register write: sticky OR, else mask/unmask on the change set.
    function automatic grp_state_t apply_enable_wr(grp_state_t s, word_t d);
        grp_state_t n;
        word_t merged;
        word_t chg;
        n = s;
        merged = s.enable | d;
        chg = s.en_reg ^ d;
        if (d == '0 && s.enable == '0) begin
            n.en_reg = d;
        end else if (merged != s.enable) begin
            n.enable = merged;
            n.en_reg = d;
        end else begin
            if ((chg & d) != '0)
                n.mask = s.mask & ~chg;
            else
                n.mask = s.mask | chg;
            n.en_reg = d;
        end
        return n;
    endfunction

    // Status-register write: clear ones, then hand over pending when empty.
    function automatic grp_state_t apply_status_wr(grp_state_t s, word_t d);
        grp_state_t n;
        n = s;
        if (d != '0) begin
            n.status = s.status & ~d;
            if (d != '1 && n.status == '0) begin
                if (s.pending != '0) begin
                    n.status  = s.pending;
                    n.pending = '0;
                    n.irq     = 1'b1;
                end else begin
                    n.irq = 1'b0;
                end
            end
        end
        return n;
    endfunction

    // Source event: open a batch when idle, otherwise collect into pending.
    function automatic grp_state_t apply_event(grp_state_t s, word_t lines);
        grp_state_t n;
        word_t sel;
        n = s;
        sel = lines & s.enable;
        if (sel != '0) begin
            if (s.mask != '0 || s.status != '0) begin
                n.pending = s.pending | sel;
            end else begin
                n.status = sel;
                n.irq    = 1'b1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/intagg_decode.sv
module intagg_decode
    import intagg_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [GRP_W-1:0]  grp,
    output logic [ADDR_W-3:0] word_idx
);
    localparam int unsigned OFF_W = GRP_LO - 2;

    logic             in_win;
    logic [OFF_W-1:0] off_w;
    logic             grp_ok;

    assign grp      = addr[GRP_LO +: GRP_W];
    assign off_w    = addr[GRP_LO-1:2];
    assign word_idx = addr[ADDR_W-1:2];
    assign in_win   = 32'(addr) < WIN_BYTES;
    assign grp_ok   = 32'(grp) < NUM_GROUPS;

    always_comb begin
        kind = ACC_NONE;
        if (in_win) begin
            if (off_w == OFF_W'(0))
                kind = grp_ok ? ACC_ENABLE : ACC_NONE;
            else if (off_w == OFF_W'(1))
                kind = grp_ok ? ACC_STATUS : ACC_NONE;
            else
                kind = ACC_PLAIN;
        end
    end
endmodule

// File: rtl/intagg_store.sv
module intagg_store
    import intagg_pkg::*;
#(
    parameter int unsigned WORDS = WIN_WORDS,
    parameter int unsigned IDX_W = ADDR_W - 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  word_t            wdata,
    output word_t            rdata
);
    word_t mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(WORDS); i++) mem[i] <= '0;
        end else if (we && 32'(idx) < WORDS) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = (32'(idx) < WORDS) ? mem[idx] : '0;
endmodule

// File: rtl/intagg_group.sv
module intagg_group
    import intagg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_wr,
    input  logic  st_wr,
    input  word_t wdata,
    input  word_t lines,
    output word_t en_reg,
    output word_t enable,
    output word_t status,
    output logic  irq
);
    grp_state_t cur, after_wr, nxt;

    always_comb begin
        after_wr = cur;
        if (en_wr)
            after_wr = apply_enable_wr(cur, wdata);
        else if (st_wr)
            after_wr = apply_status_wr(cur, wdata);
        // the write is settled before the source event is judged
        nxt = apply_event(after_wr, lines);
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign en_reg = cur.en_reg;
    assign enable = cur.enable;
    assign status = cur.status;
    assign irq    = cur.irq;
endmodule

// File: rtl/intagg_top.sv
module intagg_top
    import intagg_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 9
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_we,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [WORD_W-1:0]              bus_wdata,
    output logic [WORD_W-1:0]              bus_rdata,
    input  logic [NUM_GROUPS*WORD_W-1:0]   src_lines,
    output logic [NUM_GROUPS-1:0]          irq_out
);
    localparam int unsigned GRP_SLOTS = 1 << GRP_W;

    acc_kind_e           kind;
    logic [GRP_W-1:0]    grp;
    logic [ADDR_W-3:0]   word_idx;
    word_t               store_rd;

    logic [GRP_SLOTS-1:0][WORD_W-1:0] en_reg_slots;
    logic [GRP_SLOTS-1:0][WORD_W-1:0] en_word_slots;
    logic [GRP_SLOTS-1:0][WORD_W-1:0] st_slots;

    intagg_decode #(.NUM_GROUPS(NUM_GROUPS)) u_dec (
        .addr     (bus_addr),
        .kind     (kind),
        .grp      (grp),
        .word_idx (word_idx)
    );

    intagg_store #(.WORDS(WIN_WORDS), .IDX_W(ADDR_W-2)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we && kind == ACC_PLAIN),
        .idx   (word_idx),
        .wdata (bus_wdata),
        .rdata (store_rd)
    );

    for (genvar g = 0; g < int'(GRP_SLOTS); g++) begin : g_slot
        if (g < int'(NUM_GROUPS)) begin : g_live
            logic hit;
            assign hit = (grp == GRP_W'(g));
            intagg_group u_grp (
                .clk    (clk),
                .rst    (rst),
                .en_wr  (bus_we && kind == ACC_ENABLE && hit),
                .st_wr  (bus_we && kind == ACC_STATUS && hit),
                .wdata  (bus_wdata),
                .lines  (src_lines[g*WORD_W +: WORD_W]),
                .en_reg (en_reg_slots[g]),
                .enable (en_word_slots[g]),
                .status (st_slots[g]),
                .irq    (irq_out[g])
            );
        end else begin : g_empty
            assign en_reg_slots[g]  = '0;
            assign en_word_slots[g] = '0;
            assign st_slots[g]      = '0;
        end
    end

    always_comb begin
        unique case (kind)
            ACC_ENABLE: bus_rdata = en_reg_slots[grp];
            ACC_STATUS: bus_rdata = st_slots[grp];
            ACC_PLAIN:  bus_rdata = store_rd;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/intagg_chk.sv
module intagg_chk #(
    parameter int unsigned NG    = 9,
    parameter int unsigned SLOTS = 16,
    parameter int unsigned W     = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_we,
    input logic [NG-1:0]             irq_out,
    input logic [SLOTS-1:0][W-1:0]   en_slots,
    input logic [SLOTS-1:0][W-1:0]   st_slots
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> irq_out == '0);  // R1

    for (genvar g = 0; g < int'(NG); g++) begin : g_chk
        AST_RISE_HAS_BATCH: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_out[g]) |-> st_slots[g] != '0);  // R4
        AST_OPEN_BATCH_HELD: assert property (@(posedge clk) disable iff (rst)
            (st_slots[g] != '0 && !bus_we) |=> $stable(st_slots[g]));  // R6
        AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (rst)
            ($past(en_slots[g]) & ~en_slots[g]) == '0);  // R7
        AST_DROP_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
            $fell(irq_out[g]) |-> $past(bus_we));  // R12
    end
endmodule

bind intagg_top intagg_chk #(
    .NG    (NUM_GROUPS),
    .SLOTS (GRP_SLOTS),
    .W     (WORD_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .irq_out  (irq_out),
    .en_slots (en_word_slots),
    .st_slots (st_slots)
);

// File: tb/intagg_top_tb.sv
module intagg_top_tb;
    localparam int NG = 9;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_we = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NG*32-1:0] src = '0;
    logic [NG-1:0]   irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    intagg_top #(.NUM_GROUPS(NG)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_lines (src),
        .irq_out   (irq_out)
    );

    always #4 clk = ~clk;

    // {addr, write data, expected readback}
    localparam logic [75:0] VEC [8] = '{
        {12'h008, 32'hDEADBEEF, 32'hDEADBEEF},
        {12'h0FC, 32'h12345678, 32'h12345678},
        {12'h7F0, 32'hA5A5A5A5, 32'hA5A5A5A5},
        {12'h800, 32'h0000F00F, 32'h0000F00F},
        {12'h300, 32'h00000003, 32'h00000003},
        {12'h808, 32'hFFFFFFFF, 32'h00000000},
        {12'hC00, 32'h11111111, 32'h00000000},
        {12'h0F8, 32'h00000000, 32'h00000000}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic pulse(input int g, input logic [31:0] v);
        src[g*32 +: 32] = v;
        @(negedge clk);
        src = '0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete, got 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(12'h000, v); chk("R1 enable0", v, 32'h0);
        rd(12'h804, v); chk("R1 status8", v, 32'h0);
        rd(12'h010, v); chk("R1 plain", v, 32'h0);
        chk("R1 irq", 32'(irq_out), 32'h0);

        // R2 / R3: address map table
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][75:64], VEC[i][63:32]);
            rd(VEC[i][75:64], v);
            chk("R2/R3 table", v, VEC[i][31:0]);
        end
        chk("R3 irq quiet", 32'(irq_out), 32'h0);

        // group 0
        wr(12'h000, 32'h000000FF);
        rd(12'h000, v); chk("R2 enable readback", v, 32'hFF);
        pulse(0, 32'h00000100);
        rd(12'h004, v); chk("R5 status", v, 32'h0);
        chk("R5 irq", 32'(irq_out[0]), 32'h0);
        pulse(0, 32'h00000003);
        rd(12'h004, v); chk("R4 status", v, 32'h3);
        chk("R4 irq", 32'(irq_out[0]), 32'h1);
        pulse(0, 32'h00000004);
        rd(12'h004, v); chk("R6 status held", v, 32'h3);
        chk("R6 irq", 32'(irq_out[0]), 32'h1);
        wr(12'h004, 32'h0);
        rd(12'h004, v); chk("R10 zero write", v, 32'h3);
        wr(12'h004, 32'h1);
        rd(12'h004, v); chk("R10 partial clear", v, 32'h2);
        chk("R10 irq", 32'(irq_out[0]), 32'h1);
        wr(12'h004, 32'h2);
        rd(12'h004, v); chk("R12 pending loaded", v, 32'h4);
        chk("R12 irq kept", 32'(irq_out[0]), 32'h1);
        wr(12'h004, 32'h4);
        rd(12'h004, v); chk("R12 empty", v, 32'h0);
        chk("R12 irq low", 32'(irq_out[0]), 32'h0);

        // group 1: all-ones acknowledge
        wr(12'h100, 32'h0000000F);
        pulse(1, 32'h1);
        pulse(1, 32'h2);
        wr(12'h104, 32'hFFFFFFFF);
        rd(12'h104, v); chk("R11 status cleared", v, 32'h0);
        chk("R11 irq kept", 32'(irq_out[1]), 32'h1);
        wr(12'h104, 32'h8);
        rd(12'h104, v); chk("R11 pending kept", v, 32'h2);
        wr(12'h104, 32'h2);
        chk("R12 irq low g1", 32'(irq_out[1]), 32'h0);

        // group 2: mask and unmask
        wr(12'h200, 32'h0000000F);
        wr(12'h200, 32'h0);
        rd(12'h200, v); chk("R8 readback", v, 32'h0);
        pulse(2, 32'h1);
        rd(12'h204, v); chk("R8 masked status", v, 32'h0);
        chk("R8 masked irq", 32'(irq_out[2]), 32'h0);
        wr(12'h200, 32'h0000000F);
        pulse(2, 32'h2);
        rd(12'h204, v); chk("R9/R7 unmasked delivery", v, 32'h2);
        chk("R9 irq", 32'(irq_out[2]), 32'h1);
        wr(12'h204, 32'h2);
        rd(12'h204, v); chk("R12 masked pending", v, 32'h1);
        wr(12'h204, 32'h1);
        chk("R12 irq low g2", 32'(irq_out[2]), 32'h0);

        // R13: write and event in one cycle
        src[2*32 +: 32] = 32'h10;
        wr(12'h200, 32'h30);
        src = '0;
        rd(12'h204, v); chk("R13 write first", v, 32'h10);
        chk("R13 irq", 32'(irq_out[2]), 32'h1);
        wr(12'h204, 32'h10);
        chk("R13 irq low", 32'(irq_out[2]), 32'h0);

        // R7: zero write on a zero enable word only stores
        wr(12'h600, 32'h0);
        pulse(6, 32'hFFFFFFFF);
        chk("R7 zero enable", 32'(irq_out[6]), 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule